// File: doc/BRIEF.md
# Overloaded Command Router

The router sits between an instruction pipeline and a small set of attached execution devices. The pipeline issues one of eight overloaded commands with two source operands. The low twelve bits of the first operand hold a unit number. The router turns that number into exactly one device and hands that device the command index and both operands, unchanged. It then waits for the device's single result and returns it on a response port.

Unit number zero is reserved and never reaches a device. A unit number that no device owns is treated in the same way. Such a request completes on its own in one cycle, without any device being involved. A policy input picks how it completes. It can raise a trap. It can also return a quiet fallback value of all zeros or all ones, without a trap.

Only one request is in flight at a time. The request port is ready only while the router is idle.

Top module: `cmd_router`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and every bit of `dev_valid` are 0.
- R2: The unit number is `req_src1[11:0]`. Bits above 11 never affect routing. Device i owns unit number UNIT_BASE+i (default UNIT_BASE=1, four devices, so units 1 to 4).
- R3: While a request is offered to device i, only `dev_valid[i]` is high. Its slices of `dev_cmd`, `dev_src1` and `dev_src2` carry the accepted command and operands bit for bit. The slices of every other device read zero.
- R4: `dev_valid` and the offered command and operands stay unchanged until the device raises its `dev_ready`. The handshake completes on the clock edge where both are high.
- R5: After that handshake, the first `dev_result_valid` from the selected device is returned. In the following cycle `rsp_valid` is 1, `rsp_data` equals that device's `dev_result` and `rsp_trap` is 0.
- R6: A request with unit number 0 never raises any `dev_valid`. With `miss_policy` 2'b00 or 2'b11 it responds with `rsp_trap`=1 and `rsp_data`=0.
- R7: A nonzero unit number that no device owns is handled exactly as unit 0, including its policy and its timing.
- R8: With `miss_policy` 2'b01 a missed request returns `rsp_data`=0. With 2'b10 it returns all ones. In both cases `rsp_trap` is 0.
- R9: A missed request has `rsp_valid` high in the cycle right after the edge that accepted it.
- R10: Each accepted request (`req_valid` and `req_ready` high at an edge) produces exactly one cycle of `rsp_valid`. `req_ready` is low from acceptance until that response cycle has passed.
- R11: A `dev_result_valid` pulse is ignored when it comes from a device other than the selected one, or arrives while no handshaken request is waiting. No extra response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_policy | input | 2 | Miss handling: 00/11 trap, 01 zeros, 10 all ones |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Router idle, request accepted when strobe high |
| req_cmd | input | 3 | Command slot index 0 to 7 |
| req_src1 | input | 64 | First operand, unit number in bits 11:0 |
| req_src2 | input | 64 | Second operand |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Result or fallback value |
| rsp_trap | output | 1 | Request faulted |
| dev_valid | output | N_DEV | Per-device request strobe |
| dev_ready | input | N_DEV | Per-device request accept |
| dev_cmd | output | 3*N_DEV | Per-device command slot |
| dev_src1 | output | 64*N_DEV | Per-device first operand |
| dev_src2 | output | 64*N_DEV | Per-device second operand |
| dev_result | input | 64*N_DEV | Per-device result |
| dev_result_valid | input | N_DEV | Per-device result strobe |

## Verification
The bench sends operands whose upper bits look like a valid unit, such as 0x1000 and 0x1001. A decoder that reads too wide a field would send these to the wrong device or trap them when it should not. Each device's result is a function of its own index as well as of the operands, so a wrong routing, a swapped operand or a copied command shows up as a mismatched result. Decoy result pulses come from idle and unselected devices. A router that does not qualify results by selection and phase would answer early with wrong data, or answer twice. Misses to unit 0 and to unowned units, such as 5 and 0xFFF, are run under all four policies. A router that lets a miss reach a device, traps in a quiet mode, or answers late would be caught here.

// File: rtl/cmd_router_pkg.sv
package cmd_router_pkg;

    parameter int XLEN   = 64;
    parameter int CMD_W  = 3;
    parameter int UNIT_W = 12;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [UNIT_W-1:0] unit_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        MP_TRAP     = 2'b00,
        MP_ZERO     = 2'b01,
        MP_ONES     = 2'b10,
        MP_TRAP_ALT = 2'b11
    } miss_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        word_t            src1;
        word_t            src2;
    } req_t;

    typedef struct packed {
        word_t data;
        logic  trap;
    } rsp_t;

    function automatic unit_t unit_of(word_t s);
        return s[UNIT_W-1:0];
    endfunction

    function automatic rsp_t miss_rsp(logic [1:0] pol);
        rsp_t r;
        case (pol)
            MP_ZERO: begin r.data = '0; r.trap = 1'b0; end
            MP_ONES: begin r.data = '1; r.trap = 1'b0; end
            default: begin r.data = '0; r.trap = 1'b1; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cru_decode.sv
module cru_decode
    import cmd_router_pkg::*;
#(
    parameter int N_DEV     = 4,
    parameter int UNIT_BASE = 1
) (
    input  unit_t            unit,
    output logic [N_DEV-1:0] hit_oh,
    output logic             hit
);
    localparam unit_t ZERO_UNIT = '0;

    for (genvar i = 0; i < N_DEV; i++) begin : g_match
        localparam unit_t OWN = UNIT_W'(UNIT_BASE + i);
        assign hit_oh[i] = (unit != ZERO_UNIT) && (unit == OWN);
    end

    assign hit = |hit_oh;

endmodule

// File: rtl/cru_fanout.sv
module cru_fanout
    import cmd_router_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic                   issue,
    input  logic [N_DEV-1:0]       sel_oh,
    input  req_t                   req,
    input  logic [N_DEV-1:0]       dev_ready,
    input  logic [N_DEV*XLEN-1:0]  dev_result,
    input  logic [N_DEV-1:0]       dev_result_valid,
    output logic [N_DEV-1:0]       dev_valid,
    output logic [N_DEV*CMD_W-1:0] dev_cmd,
    output logic [N_DEV*XLEN-1:0]  dev_src1,
    output logic [N_DEV*XLEN-1:0]  dev_src2,
    output logic                   sel_ready,
    output word_t                  sel_result,
    output logic                   sel_result_valid
);
    for (genvar i = 0; i < N_DEV; i++) begin : g_port
        logic show;
        assign show = issue & sel_oh[i];
        assign dev_valid[i]                 = show;
        assign dev_cmd[i*CMD_W +: CMD_W]    = show ? req.cmd  : '0;
        assign dev_src1[i*XLEN +: XLEN]     = show ? req.src1 : '0;
        assign dev_src2[i*XLEN +: XLEN]     = show ? req.src2 : '0;
    end

    always_comb begin
        sel_ready        = 1'b0;
        sel_result       = '0;
        sel_result_valid = 1'b0;
        for (int i = 0; i < N_DEV; i++) begin
            if (sel_oh[i]) begin
                sel_ready        = sel_ready | dev_ready[i];
                sel_result       = sel_result | dev_result[i*XLEN +: XLEN];
                sel_result_valid = sel_result_valid | dev_result_valid[i];
            end
        end
    end

endmodule

// File: rtl/cru_ctrl.sv
module cru_ctrl
    import cmd_router_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       miss_policy,
    input  logic             req_valid,
    output logic             req_ready,
    input  req_t             req_in,
    input  logic             hit,
    input  logic [N_DEV-1:0] hit_oh,
    input  logic             sel_ready,
    input  word_t            sel_result,
    input  logic             sel_result_valid,
    output logic             issue,
    output logic [N_DEV-1:0] sel_oh,
    output req_t             req_q,
    output logic             rsp_valid,
    output word_t            rsp_data,
    output logic             rsp_trap
);
    st_e  st;
    rsp_t rsp_q;
    logic accept;

    assign accept    = req_valid && (st == ST_IDLE);
    assign req_ready = (st == ST_IDLE);
    assign issue     = (st == ST_ISSUE);
    assign rsp_valid = (st == ST_RESP);
    assign rsp_data  = rsp_q.data;
    assign rsp_trap  = rsp_q.trap;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sel_oh <= '0;
            req_q  <= '0;
            rsp_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    req_q <= req_in;
                    if (hit) begin
                        sel_oh <= hit_oh;
                        st     <= ST_ISSUE;
                    end else begin
                        rsp_q <= miss_rsp(miss_policy);
                        st    <= ST_RESP;
                    end
                end
                ST_ISSUE: if (sel_ready) st <= ST_WAIT;
                ST_WAIT: if (sel_result_valid) begin
                    rsp_q <= '{data: sel_result, trap: 1'b0};
                    st    <= ST_RESP;
                end
                default: begin
                    sel_oh <= '0;
                    st     <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: a miss answers in the next cycle
    a_r9_miss_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit) |=> rsp_valid);

    // R6, R7: trap policies fault with zero data
    a_r6_trap_policy: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit && (miss_policy == MP_TRAP || miss_policy == MP_TRAP_ALT))
        |=> (rsp_trap && rsp_data == '0));

    // R8: quiet policies never trap
    a_r8_zero_fallback: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit && miss_policy == MP_ZERO) |=> (!rsp_trap && rsp_data == '0));
    a_r8_ones_fallback: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit && miss_policy == MP_ONES) |=> (!rsp_trap && rsp_data == '1));

    // R5: device result is returned one cycle later
    a_r5_result_return: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && sel_result_valid)
        |=> (rsp_valid && !rsp_trap && rsp_data == $past(sel_result)));

    // R10: one response cycle per request, no new request meanwhile
    a_r10_single_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> !req_ready);

    // R11: idle without a request stays quiet
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !req_valid) |=> !rsp_valid);

endmodule

// File: rtl/cmd_router.sv
module cmd_router
    import cmd_router_pkg::*;
#(
    parameter int N_DEV     = 4,
    parameter int UNIT_BASE = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             miss_policy,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [CMD_W-1:0]       req_cmd,
    input  logic [XLEN-1:0]        req_src1,
    input  logic [XLEN-1:0]        req_src2,
    output logic                   rsp_valid,
    output logic [XLEN-1:0]        rsp_data,
    output logic                   rsp_trap,
    output logic [N_DEV-1:0]       dev_valid,
    input  logic [N_DEV-1:0]       dev_ready,
    output logic [N_DEV*CMD_W-1:0] dev_cmd,
    output logic [N_DEV*XLEN-1:0]  dev_src1,
    output logic [N_DEV*XLEN-1:0]  dev_src2,
    input  logic [N_DEV*XLEN-1:0]  dev_result,
    input  logic [N_DEV-1:0]       dev_result_valid
);
    req_t             req_in;
    req_t             req_q;
    logic [N_DEV-1:0] hit_oh;
    logic [N_DEV-1:0] sel_oh;
    logic             hit;
    logic             issue;
    logic             sel_ready;
    word_t            sel_result;
    logic             sel_result_valid;

    assign req_in = '{cmd: req_cmd, src1: req_src1, src2: req_src2};

    cru_decode #(.N_DEV(N_DEV), .UNIT_BASE(UNIT_BASE)) u_decode (
        .unit   (unit_of(req_src1)),
        .hit_oh (hit_oh),
        .hit    (hit)
    );

    cru_ctrl #(.N_DEV(N_DEV)) u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .miss_policy      (miss_policy),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_in           (req_in),
        .hit              (hit),
        .hit_oh           (hit_oh),
        .sel_ready        (sel_ready),
        .sel_result       (sel_result),
        .sel_result_valid (sel_result_valid),
        .issue            (issue),
        .sel_oh           (sel_oh),
        .req_q            (req_q),
        .rsp_valid        (rsp_valid),
        .rsp_data         (rsp_data),
        .rsp_trap         (rsp_trap)
    );

    cru_fanout #(.N_DEV(N_DEV)) u_fanout (
        .issue            (issue),
        .sel_oh           (sel_oh),
        .req              (req_q),
        .dev_ready        (dev_ready),
        .dev_result       (dev_result),
        .dev_result_valid (dev_result_valid),
        .dev_valid        (dev_valid),
        .dev_cmd          (dev_cmd),
        .dev_src1         (dev_src1),
        .dev_src2         (dev_src2),
        .sel_ready        (sel_ready),
        .sel_result       (sel_result),
        .sel_result_valid (sel_result_valid)
    );

    // R3: at most one device is offered a request
    a_r3_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_valid));

    // R4: offer held until accepted
    a_r4_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (|(dev_valid & ~dev_ready))
        |=> (dev_valid == $past(dev_valid) && $stable(dev_cmd)
             && $stable(dev_src1) && $stable(dev_src2)));

    // R6: reserved unit never reaches a device
    a_r6_zero_unit_blocked: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && unit_of(req_src1) == '0) |=> (dev_valid == '0));

endmodule

// File: tb/cmd_router_test.sv
`timescale 1ns/1ps
module cmd_router_test;
    localparam int N  = 4;
    localparam int XL = 64;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      miss_policy = 2'b00;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [CW-1:0]   req_cmd = '0;
    logic [XL-1:0]   req_src1 = '0;
    logic [XL-1:0]   req_src2 = '0;
    logic            rsp_valid;
    logic [XL-1:0]   rsp_data;
    logic            rsp_trap;
    logic [N-1:0]    dev_valid;
    logic [N-1:0]    dev_ready = '0;
    logic [N*CW-1:0] dev_cmd;
    logic [N*XL-1:0] dev_src1;
    logic [N*XL-1:0] dev_src2;
    logic [N*XL-1:0] dev_result = '0;
    logic [N-1:0]    dev_result_valid = '0;

    always #4 clk = ~clk;

    cmd_router #(.N_DEV(N), .UNIT_BASE(1)) uut (
        .clk(clk), .rst(rst), .miss_policy(miss_policy),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_src1(req_src1), .req_src2(req_src2),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_trap(rsp_trap),
        .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_cmd(dev_cmd),
        .dev_src1(dev_src1), .dev_src2(dev_src2),
        .dev_result(dev_result), .dev_result_valid(dev_result_valid)
    );

    int checks = 0;
    int fails  = 0;
    logic [XL:0] exp_q[$];
    int exp_dev = -1;
    logic [CW-1:0] exp_cmd;
    logic [XL-1:0] exp_s1, exp_s2;
    int ready_lat = 0;
    int result_lat = 1;
    logic models_on = 1'b0;
    logic done = 1'b0;

    function automatic logic [XL-1:0] dev_fn(int idx, logic [CW-1:0] c,
                                            logic [XL-1:0] a, logic [XL-1:0] b);
        return (a ^ {b[31:0], b[63:32]}) + {61'b0, c}
               + 64'(idx + 1) * 64'h0001_0000_0000_0101;
    endfunction

    task automatic check(bit ok, string req, logic [XL:0] act, logic [XL:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10/R11 unexpected response", {rsp_trap, rsp_data}, '0);
            end else begin
                logic [XL:0] e;
                e = exp_q.pop_front();
                check({rsp_trap, rsp_data} === e, "R5/R6/R7/R8 response",
                      {rsp_trap, rsp_data}, e);
            end
        end
    end

    // device models and routing check
    int ph[N];
    int cnt[N];
    logic [CW-1:0] got_cmd[N];
    logic [XL-1:0] got_s1[N], got_s2[N];
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin ph[i] = 0; cnt[i] = 0; end
        end else if (models_on) begin
            dev_ready = '0;
            dev_result_valid = '0;
            if (dev_valid != '0) begin
                bit ok;
                ok = (exp_dev >= 0) && (dev_valid == N'(1 << exp_dev));
                for (int i = 0; i < N; i++) begin
                    if (i == exp_dev) begin
                        if (dev_cmd[i*CW +: CW] !== exp_cmd || dev_src1[i*XL +: XL] !== exp_s1
                            || dev_src2[i*XL +: XL] !== exp_s2) ok = 0;
                    end else if (dev_cmd[i*CW +: CW] !== '0 || dev_src1[i*XL +: XL] !== '0
                                 || dev_src2[i*XL +: XL] !== '0) ok = 0;
                end
                check(ok, "R3/R6 routing", {61'b0, dev_valid}, 65'(exp_dev));
            end
            for (int i = 0; i < N; i++) begin
                if (ph[i] == 0) begin
                    if (dev_valid[i]) begin
                        if (cnt[i] >= ready_lat) begin
                            dev_ready[i] = 1'b1;
                            got_cmd[i] = dev_cmd[i*CW +: CW];
                            got_s1[i] = dev_src1[i*XL +: XL];
                            got_s2[i] = dev_src2[i*XL +: XL];
                            ph[i] = 1; cnt[i] = 0;
                        end else cnt[i]++;
                    end
                end else begin
                    if (cnt[i] == 0) begin
                        // R11 decoy from an unselected device
                        dev_result[((i+1)%N)*XL +: XL] = 64'hDEAD_BEEF_0BAD_F00D;
                        dev_result_valid[(i+1)%N] = 1'b1;
                    end
                    if (cnt[i] >= result_lat) begin
                        dev_result[i*XL +: XL] = dev_fn(i, got_cmd[i], got_s1[i], got_s2[i]);
                        dev_result_valid[i] = 1'b1;
                        ph[i] = 0; cnt[i] = 0;
                    end else cnt[i]++;
                end
            end
        end
    end

    task automatic send(logic [CW-1:0] c, logic [XL-1:0] a, logic [XL-1:0] b,
                        logic [1:0] pol, int rlat, int dlat);
        int u;
        logic [XL:0] e;
        u = int'(a[11:0]);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ready_lat = rlat; result_lat = dlat;
        miss_policy = pol;
        exp_cmd = c; exp_s1 = a; exp_s2 = b;
        if (u >= 1 && u <= N) begin
            exp_dev = u - 1;
            e = {1'b0, dev_fn(u - 1, c, a, b)};
        end else begin
            exp_dev = -1;
            case (pol)
                2'b01: e = {1'b0, 64'h0};
                2'b10: e = {1'b0, {64{1'b1}}};
                default: e = {1'b1, 64'h0};
            endcase
        end
        exp_q.push_back(e);
        req_cmd = c; req_src1 = a; req_src2 = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_dev < 0) begin
            // R9: response in the cycle after acceptance
            check(rsp_valid === 1'b1, "R9 miss latency", {64'b0, rsp_valid}, 65'd1);
        end else begin
            // R10: busy after acceptance
            check(req_ready === 1'b0, "R10 ready low while busy", {64'b0, req_ready}, 65'd0);
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        exp_dev = -1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1 && rsp_valid === 1'b0 && dev_valid === '0,
              "R1 reset state", {62'b0, req_ready, rsp_valid, |dev_valid}, 65'b100);
        // R11: stray results while idle
        dev_result = {N*XL{1'b1}};
        dev_result_valid = '1;
        repeat (2) @(negedge clk);
        check(rsp_valid === 1'b0, "R11 idle stray ignored", {64'b0, rsp_valid}, 65'd0);
        dev_result_valid = '0;
        models_on = 1'b1;
        // R2 R3 R4 R5: hits on each device, upper src1 bits set
        send(3'd0, 64'h0000_0000_0000_0001, 64'h1111_2222_3333_4444, 2'b00, 0, 1);
        send(3'd5, 64'hFFFF_FFFF_FFFF_F002, 64'h8000_0000_0000_0001, 2'b00, 2, 3);
        send(3'd7, 64'h0123_4567_89AB_C003, 64'hFEDC_BA98_7654_3210, 2'b01, 1, 2);
        send(3'd2, 64'h0000_0000_0000_1004, 64'h0, 2'b10, 3, 1);
        send(3'd1, 64'h0000_0000_0000_1001, 64'hA5A5_A5A5_5A5A_5A5A, 2'b00, 0, 4);
        // R6: unit zero under all policies
        send(3'd3, 64'h0, 64'h5, 2'b00, 0, 1);
        send(3'd3, 64'h0000_0000_0000_1000, 64'h5, 2'b11, 0, 1);
        send(3'd4, 64'hABCD_0000_0000_0000, 64'h5, 2'b01, 0, 1);
        send(3'd6, 64'h0, 64'h7, 2'b10, 0, 1);
        // R7: unowned units
        send(3'd1, 64'h0000_0000_0000_0005, 64'h9, 2'b00, 0, 1);
        send(3'd1, 64'h0000_0000_0000_0FFF, 64'h9, 2'b10, 0, 1);
        send(3'd0, 64'h1234_0000_0000_0800, 64'h9, 2'b01, 0, 1);
        // R8 quiet policy followed by a hit, then back to back
        send(3'd6, 64'h0000_0000_0000_0002, 64'h42, 2'b01, 1, 1);
        for (int k = 0; k < 8; k++) begin
            send(CW'(k), {32'(k * 7919), 20'h0, 12'(k % 6)}, 64'(k) << 40, 2'(k), k % 3, 1 + k % 2);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 all responses seen", 65'(exp_q.size()), 65'd0);
        finish_run();
    end

endmodule